// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge driver. It turns a decoded PWM command (drive high, drive low, or float) into two gate enables, one for the high-side switch and one for the low-side switch. It never lets both switches conduct at once. The dead time between them is not a fixed count. The block waits for digitised feedback showing that the gate being released has actually fallen below its turn-on threshold. Only then does it enable the other gate.

A programmable fallback timer bounds that wait. If the feedback never arrives, the pending gate is forced on and a timeout flag is raised. When diode emulation is enabled, the low side conducts during the low phase only until the inductor current reaches zero. After that it stays off for the rest of the cycle. The disable and undervoltage inputs take precedence over everything else and clamp both gates off within the same cycle. On leaving either condition, the block keeps both gates off until the command changes value. A glitch filter rejects command pulses shorter than a programmable number of clock cycles.

Top module: `adt_gate_seq`

## Requirements
- R1: `hs_on` and `ls_on` are never both 1.
- R2: After the filtered command changes to high, `hs_on` stays 0 while `lg_low` is 0. It rises on the clock edge that samples `lg_low` = 1 during the wait, one cycle after the wait state is entered at the earliest.
- R3: After the filtered command changes to low, `ls_on` stays 0 while `hg_low` is 0. It rises on the clock edge that samples `hg_low` = 1 during the wait.
- R4: If the expected feedback is still absent after `max_dead` cycles in a wait, the pending gate is forced on and status bit 0 (timeout) is set. The flag stays set until the block next enters shutdown. With `min_pulse` = 2 and `max_dead` = 6, a high command whose feedback never comes turns `hs_on` on 9 clock edges after the command is first applied.
- R5: While `dis_n` is 0, both gates are 0 in the same cycle (combinationally) and status bit 1 (shutdown) is 1.
- R6: While `uv` is 1, both gates are 0 in the same cycle and status bit 1 is 1.
- R7: After shutdown ends, both gates stay 0 until the filtered command takes a value different from the one it held when shutdown ended.
- R8: A command of `pwm_cmd` = 2'b10 or 2'b11 (float) turns both gates off. Code 2'b00 means drive low and 2'b01 means drive high.
- R9: With `demu_n` = 0 during a low command, the low side turns off when `zcd` is sampled 1 and stays off until the command changes, even if `zcd` returns to 0. This includes a `zcd` seen during the dead-time wait. Status bit 2 is 1 while the low side is skipped.
- R10: With `demu_n` = 1, `zcd` is ignored and a low command keeps `ls_on` at 1.
- R11: A new command value takes effect only after it has been sampled on `min_pulse` consecutive clock edges. A shorter pulse leaves the gates unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 2 | Decoded command: 00 low, 01 high, 1x float |
| dis_n | input | 1 | Active-low disable |
| demu_n | input | 1 | Active-low diode-emulation enable |
| uv | input | 1 | Undervoltage asserted |
| lg_low | input | 1 | Low-side gate below turn-on threshold |
| hg_low | input | 1 | High-side gate-to-source below turn-on threshold |
| zcd | input | 1 | Inductor current zero crossing detected |
| max_dead | input | TW | Fallback dead-time limit in cycles |
| min_pulse | input | TW | Minimum accepted command length in cycles |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| status | output | 3 | bit2 skip active, bit1 shutdown, bit0 timeout |

## Verification
A wrong sequencer state appears directly on the gate pins. A stuck wait state leaves both gates low well past the point where the feedback arrived. A state that skips the wait turns a gate on one cycle too early, before feedback. A lost skip state shows up as `ls_on` returning in the same low phase. The bench samples the gates at the exact edges where feedback, timeout and filter delays predict a change, so an error of one cycle in any counter shows up as a miscompare at that edge. The shutdown clamp is sampled within the same cycle as the input change. A registered clamp therefore fails at once.

// File: rtl/adt_gseq_pkg.sv
package adt_gseq_pkg;

    typedef enum logic [1:0] {
        CMD_LOW  = 2'b00,
        CMD_HIGH = 2'b01,
        CMD_OFF  = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        ST_SHUT,
        ST_ARM,
        ST_OFF,
        ST_WAIT_HS,
        ST_HS_ON,
        ST_WAIT_LS,
        ST_LS_ON,
        ST_SKIP
    } state_e;

    typedef struct packed {
        logic skip;
        logic shutdown;
        logic timeout;
    } status_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gates_t;

    localparam int STAT_W = $bits(status_t);
    localparam int CMD_W  = 2;

    function automatic cmd_e decode_cmd(input logic [CMD_W-1:0] raw);
        if (raw[1])
            return CMD_OFF;
        else if (raw[0])
            return CMD_HIGH;
        else
            return CMD_LOW;
    endfunction

    function automatic logic is_wait(input state_e s);
        return (s == ST_WAIT_HS) || (s == ST_WAIT_LS);
    endfunction

    function automatic gates_t gate_map(input state_e s);
        gates_t g;
        g.hs = (s == ST_HS_ON);
        g.ls = (s == ST_LS_ON);
        return g;
    endfunction

endpackage

// File: rtl/adt_gseq_cmd_filter.sv
module adt_gseq_cmd_filter
    import adt_gseq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] raw_cmd,
    input  logic [TW-1:0]    min_pulse,
    output cmd_e             cmd
);
    localparam logic [TW-1:0] RUN_MAX = {TW{1'b1}};
    localparam logic [TW-1:0] RUN_ONE = {{(TW-1){1'b0}}, 1'b1};

    cmd_e          cmd_q;
    cmd_e          cand_q;
    logic [TW-1:0] run_q;
    cmd_e          dec;
    logic [TW-1:0] run_nx;
    logic          accept;

    always_comb begin
        dec = decode_cmd(raw_cmd);
        if (dec == cand_q && run_q != '0)
            run_nx = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;
        else
            run_nx = RUN_ONE;
        accept = (run_nx >= min_pulse);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_OFF;
            cand_q <= CMD_OFF;
            run_q  <= '0;
        end else begin
            cand_q <= dec;
            if (dec == cmd_q) begin
                run_q <= '0;
            end else if (accept) begin
                cmd_q <= dec;
                run_q <= '0;
            end else begin
                run_q <= run_nx;
            end
        end
    end

    assign cmd = cmd_q;

endmodule

// File: rtl/adt_gseq_dead_timer.sv
module adt_gseq_dead_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          restart,
    input  logic [TW-1:0] max_dead,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_q;
    logic [TW:0]   elapsed;

    always_comb begin
        elapsed = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
        expired = active && (elapsed >= {1'b0, max_dead});
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !active)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/adt_gseq_fsm.sv
module adt_gseq_fsm
    import adt_gseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cmd_e    cmd,
    input  logic    dis_n,
    input  logic    demu_n,
    input  logic    uv,
    input  logic    lg_low,
    input  logic    hg_low,
    input  logic    zcd,
    input  logic    expired,
    output logic    in_wait,
    output logic    restart,
    output logic    hs_on,
    output logic    ls_on,
    output status_t status
);
    state_e state_q;
    state_e nx;
    state_e src;
    cmd_e   ref_q;
    logic   to_q;
    logic   shut_now;
    logic   skip_hit;
    logic   to_set;
    gates_t g;

    always_comb begin
        shut_now = !dis_n || uv;
        skip_hit = !demu_n && zcd;
        src      = state_q;
        nx       = state_q;
        if (shut_now) begin
            nx = ST_SHUT;
        end else if (state_q == ST_SHUT) begin
            nx = ST_ARM;
        end else if (state_q == ST_ARM && cmd == ref_q) begin
            nx = ST_ARM;
        end else begin
            if (state_q == ST_ARM)
                src = ST_OFF;
            case (cmd)
                CMD_OFF: nx = ST_OFF;
                CMD_HIGH: begin
                    case (src)
                        ST_HS_ON:   nx = ST_HS_ON;
                        ST_WAIT_HS: nx = (lg_low || expired) ? ST_HS_ON : ST_WAIT_HS;
                        default:    nx = ST_WAIT_HS;
                    endcase
                end
                default: begin
                    case (src)
                        ST_WAIT_LS: begin
                            if (skip_hit)
                                nx = ST_SKIP;
                            else if (hg_low || expired)
                                nx = ST_LS_ON;
                            else
                                nx = ST_WAIT_LS;
                        end
                        ST_LS_ON: nx = skip_hit ? ST_SKIP : ST_LS_ON;
                        ST_SKIP:  nx = ST_SKIP;
                        default:  nx = ST_WAIT_LS;
                    endcase
                end
            endcase
        end
        to_set = ((state_q == ST_WAIT_HS) && (nx == ST_HS_ON) && !lg_low) ||
                 ((state_q == ST_WAIT_LS) && (nx == ST_LS_ON) && !hg_low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SHUT;
            ref_q   <= CMD_OFF;
            to_q    <= 1'b0;
        end else begin
            state_q <= nx;
            if (state_q == ST_SHUT)
                ref_q <= cmd;
            if (nx == ST_SHUT)
                to_q <= 1'b0;
            else if (to_set)
                to_q <= 1'b1;
        end
    end

    always_comb begin
        g               = gate_map(state_q);
        hs_on           = g.hs && !shut_now;
        ls_on           = g.ls && !shut_now;
        in_wait         = is_wait(state_q);
        restart         = is_wait(nx) && (nx != state_q);
        status.skip     = (state_q == ST_SKIP);
        status.shutdown = shut_now || (state_q == ST_SHUT);
        status.timeout  = to_q;
    end

endmodule

// File: rtl/adt_gate_seq.sv
module adt_gate_seq
    import adt_gseq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  pwm_cmd,
    input  logic              dis_n,
    input  logic              demu_n,
    input  logic              uv,
    input  logic              lg_low,
    input  logic              hg_low,
    input  logic              zcd,
    input  logic [TW-1:0]     max_dead,
    input  logic [TW-1:0]     min_pulse,
    output logic              hs_on,
    output logic              ls_on,
    output logic [STAT_W-1:0] status
);
    cmd_e    cmd_f;
    logic    expired;
    logic    in_wait;
    logic    restart;
    status_t stat_s;

    adt_gseq_cmd_filter #(.TW(TW)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .raw_cmd   (pwm_cmd),
        .min_pulse (min_pulse),
        .cmd       (cmd_f)
    );

    adt_gseq_dead_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .active   (in_wait),
        .restart  (restart),
        .max_dead (max_dead),
        .expired  (expired)
    );

    adt_gseq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_f),
        .dis_n   (dis_n),
        .demu_n  (demu_n),
        .uv      (uv),
        .lg_low  (lg_low),
        .hg_low  (hg_low),
        .zcd     (zcd),
        .expired (expired),
        .in_wait (in_wait),
        .restart (restart),
        .hs_on   (hs_on),
        .ls_on   (ls_on),
        .status  (stat_s)
    );

    assign status = stat_s;

endmodule

// File: rtl/adt_gate_seq_chk.sv
module adt_gate_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       dis_n,
    input logic       uv,
    input logic       hs_on,
    input logic       ls_on,
    input logic [2:0] status
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !(hs_on && ls_on)); // R1

    AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_on) |-> $past(!ls_on)); // R2

    AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_on) |-> $past(!hs_on)); // R3

    AST_TIMEOUT_FORCES_GATE: assert property (@(posedge clk) disable iff (rst)
        ($rose(status[0]) && dis_n && !uv) |-> (hs_on || ls_on)); // R4

    AST_DISABLE_CLAMP: assert property (@(posedge clk) disable iff (rst)
        !dis_n |-> (!hs_on && !ls_on && status[1])); // R5

    AST_UV_CLAMP: assert property (@(posedge clk) disable iff (rst)
        uv |-> (!hs_on && !ls_on && status[1])); // R6

    AST_EXIT_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(!dis_n || uv) && dis_n && !uv) |-> (!hs_on && !ls_on)); // R7

endmodule

bind adt_gate_seq adt_gate_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .dis_n  (dis_n),
    .uv     (uv),
    .hs_on  (hs_on),
    .ls_on  (ls_on),
    .status (status)
);

// File: tb/adt_gate_seq_tb.sv
module adt_gate_seq_tb;
    localparam int PERIOD = 10;
    localparam int TW     = 8;
    localparam int NV     = 20;

    typedef struct packed {
        logic [1:0] pwm;
        logic       dis_n;
        logic       demu_n;
        logic       uv;
        logic       lg;
        logic       hg;
        logic       zc;
        logic [3:0] hold;
        logic       ehs;
        logic       els;
        logic       eto;
        logic [3:0] req;
    } vec_t;

    // pwm dis demu uv lg hg zc hold | hs ls to | req
    localparam vec_t VECS [NV] = '{
        '{2'b10,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd7},  // R7 idle after reset
        '{2'b01,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b0, 4'd2},  // R2
        '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b1,1'b0, 4'd3},  // R3
        '{2'b01,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd4},  // R4 still waiting
        '{2'b01,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b1, 4'd4},  // R4 forced on
        '{2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b1,1'b1, 4'd9},  // R9 low side on
        '{2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd5, 1'b0,1'b0,1'b1, 4'd9},  // R9 zero cross
        '{2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b1, 4'd9},  // R9 stays off
        '{2'b01,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b1, 4'd2},  // R2
        '{2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd5, 1'b0,1'b0,1'b1, 4'd9},  // R9 zc in wait
        '{2'b01,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b1, 4'd10}, // R10
        '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'd5, 1'b0,1'b1,1'b1, 4'd10}, // R10 zc ignored
        '{2'b10,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b1, 4'd8},  // R8
        '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b1,1'b1, 4'd8},  // R8 leave float
        '{2'b00,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd5},  // R5
        '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd7},  // R7 no edge
        '{2'b01,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b1,1'b0,1'b0, 4'd7},  // R7 fresh edge
        '{2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd6},  // R6
        '{2'b01,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b0,1'b0, 4'd7},  // R7
        '{2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5, 1'b0,1'b1,1'b0, 4'd7}   // R7
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    pwm_cmd;
    logic          dis_n, demu_n, uv, lg_low, hg_low, zcd;
    logic [TW-1:0] max_dead, min_pulse;
    logic          hs_on, ls_on;
    logic [2:0]    status;

    int n_vec = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    adt_gate_seq #(.TW(TW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pwm_cmd   (pwm_cmd),
        .dis_n     (dis_n),
        .demu_n    (demu_n),
        .uv        (uv),
        .lg_low    (lg_low),
        .hg_low    (hg_low),
        .zcd       (zcd),
        .max_dead  (max_dead),
        .min_pulse (min_pulse),
        .hs_on     (hs_on),
        .ls_on     (ls_on),
        .status    (status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pwm_cmd = 2'b10; dis_n = 1'b1; demu_n = 1'b1; uv = 1'b0;
        lg_low = 1'b1; hg_low = 1'b1; zcd = 1'b0;
        max_dead = 8'd6; min_pulse = 8'd2;
        cyc(3);
        // reset state: gates off, shutdown bit set
        chk("reset R1", {6'd0, hs_on, ls_on}, 8'h00);
        chk("reset R5", {5'd0, status}, 8'h02);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pwm_cmd = VECS[i].pwm; dis_n = VECS[i].dis_n; demu_n = VECS[i].demu_n;
            uv = VECS[i].uv; lg_low = VECS[i].lg; hg_low = VECS[i].hg; zcd = VECS[i].zc;
            cyc(int'(VECS[i].hold));
            chk($sformatf("vec%0d R%0d", i, VECS[i].req),
                {5'd0, hs_on, ls_on, status[0]},
                {5'd0, VECS[i].ehs, VECS[i].els, VECS[i].eto});
            chk($sformatf("vec%0d R1", i), {7'd0, hs_on && ls_on}, 8'h00);
        end

        // R11: one-cycle high pulse is ignored (state is low-side on)
        pwm_cmd = 2'b01;
        cyc(1);
        pwm_cmd = 2'b00;
        for (int k = 0; k < 5; k++) begin
            chk("glitch R11", {6'd0, hs_on, ls_on}, 8'h01);
            cyc(1);
        end

        // R11: two-cycle pulse is accepted, high side on after 4 edges
        pwm_cmd = 2'b01;
        cyc(2);
        pwm_cmd = 2'b00;
        cyc(2);
        chk("pulse R11", {6'd0, hs_on, ls_on}, 8'h02);
        cyc(6);
        chk("pulse back R11", {6'd0, hs_on, ls_on}, 8'h01);

        // R2: high side waits on low-gate feedback
        lg_low = 1'b0; pwm_cmd = 2'b01;
        cyc(4);
        chk("wait hs R2", {6'd0, hs_on, ls_on}, 8'h00);
        lg_low = 1'b1;
        cyc(1);
        chk("feedback hs R2", {6'd0, hs_on, ls_on}, 8'h02);

        // R3: low side waits on high-gate feedback
        hg_low = 1'b0; pwm_cmd = 2'b00;
        cyc(4);
        chk("wait ls R3", {6'd0, hs_on, ls_on}, 8'h00);
        hg_low = 1'b1;
        cyc(1);
        chk("feedback ls R3", {6'd0, hs_on, ls_on}, 8'h01);
        chk("no timeout R4", {7'd0, status[0]}, 8'h00);

        // R6: undervoltage clamps within the cycle
        pwm_cmd = 2'b01;
        cyc(5);
        chk("pre uv R2", {6'd0, hs_on, ls_on}, 8'h02);
        uv = 1'b1;
        #1;
        chk("uv clamp R6", {5'd0, hs_on, ls_on, status[1]}, 8'h01);
        cyc(2);
        uv = 1'b0; pwm_cmd = 2'b00;
        cyc(6);
        chk("uv exit edge R7", {6'd0, hs_on, ls_on}, 8'h01);

        // R5: disable clamps within the cycle
        dis_n = 1'b0;
        #1;
        chk("dis clamp R5", {5'd0, hs_on, ls_on, status[1]}, 8'h01);
        cyc(2);
        dis_n = 1'b1;
        cyc(4);
        chk("dis exit R7", {6'd0, hs_on, ls_on}, 8'h00);

        // R8: code 11 also floats
        pwm_cmd = 2'b11;
        cyc(5);
        chk("float11 R8", {6'd0, hs_on, ls_on}, 8'h00);
        pwm_cmd = 2'b00;
        cyc(5);
        chk("float exit R8", {6'd0, hs_on, ls_on}, 8'h01);
        pwm_cmd = 2'b11;
        cyc(5);
        chk("float11 again R8", {6'd0, hs_on, ls_on}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule